// File: doc/BRIEF.md
# Icon Segment RAM with Auto-Stepping Address Pointer

This block holds a small bank of icon (annunciator) dot data for a character display controller. A host writes it one byte at a time over an 8-bit bus. Before a burst it picks a step direction and loads a start address. After that, each write lands at the current pointer, and the pointer then moves one place up or down on its own. A burst of writes to consecutive entries therefore needs no further address loads.

The bank has 32 entries of 8 bits. The first 20 entries each control five icon dots, which gives a flat 100-bit segment vector that the panel driver samples in parallel. The panel's text-shift logic never touches this vector, so the icons stay fixed in place. The other twelve entries, and the top three bits of every entry, are plain scratch storage. A read port returns the whole byte at the current pointer, so the host can use that scratch space.

Top module: `icon_seg_ram`

## Requirements
- R1: A synchronous active-low reset clears all 32 entries to zero, puts the pointer at address 0, and selects the upward step direction.
- R2: `rd_data` always shows all 8 bits stored at the current pointer, including bits 7..5. Reading has no side effect.
- R3: When `ptr_load` is high at a clock edge, the pointer takes `ptr_value` at that edge. This wins over the post-write step. A write in the same cycle stores at the pointer value held before the edge.
- R4: When `dir_load` is high at a clock edge, the step direction becomes `dir_down` (1 means decrement, 0 means increment). The new direction applies from the next cycle. A write in the same cycle steps in the old direction.
- R5: When `wr_en` is high at an edge and `ptr_load` is low, `wr_data` is stored at the pointer. At that same edge the pointer moves by exactly one in the selected direction.
- R6: The pointer wraps modulo 32. A step up from 31 gives 0, and a step down from 0 gives 31.
- R7: In a cycle with no write and no load, the pointer holds its value.
- R8: For each entry n from 0 to 19 and each bit b from 0 to 4, `seg_o[5n + 4 - b]` equals bit b of entry n. Index k of `seg_o` is dot number k+1, so bit 4 of entry n is dot 5n+1 and bit 0 is dot 5n+5.
- R9: Writes to entries 20 to 31 leave `seg_o` unchanged. Changing only bits 7..5 of entries 0 to 19 also leaves `seg_o` unchanged.
- R10: A stored byte appears on `seg_o` and `rd_data` right after the clock edge that samples the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_load | input | 1 | Load the pointer from `ptr_value` |
| ptr_value | input | 5 | New pointer address |
| dir_load | input | 1 | Latch a new step direction |
| dir_down | input | 1 | Direction to latch: 1 means decrement, 0 means increment |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to store at the pointer |
| rd_data | output | 8 | Byte stored at the current pointer |
| seg_o | output | 100 | Icon dot vector, index k is dot k+1 |

## Verification
The checker assumes at most one write per cycle. It also assumes that `ptr_value` and `dir_down` carry defined values whenever their strobes are high, because the stepped, loaded and direction properties compare against the sampled values of those inputs. The bench drives every input from a defined value at the falling edge and holds each strobe for exactly one cycle. It drops the strobes before sampling outputs at the next falling edge. The only cycles in which strobes overlap are the ones set up on purpose to exercise load priority and direction timing.

// File: rtl/icon_ram_pkg.sv
// Package: shared types for the icon segment RAM.
// Assumes: only the two step directions below exist.
package icon_ram_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } step_dir_e;

endpackage

// File: rtl/icon_addr_ctr.sv
// Module: write pointer with a latched step direction.
// Loads take priority over the post-write step. Wrap comes from the
// natural modulo of an ADDR_W-bit counter (the depth is a power of two).
module icon_addr_ctr
    import icon_ram_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              dir_set,
    input  logic              dir_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr,
    output step_dir_e         mode
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Pointer update: reset, then load, then step in the current direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= (mode == DIR_DOWN) ? (ptr - ONE) : (ptr + ONE);
        end
    end

    // Direction register: takes effect from the cycle after it is set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= DIR_UP;
        end else if (dir_set) begin
            mode <= step_dir_e'(dir_val);
        end
    end

endmodule

// File: rtl/icon_store.sv
// Module: register-based byte array with one write port and one
// combinational read port. It also exposes the low dot bits of the
// display entries in parallel.
// Assumes: DISP <= DEPTH and DOTS <= DATA_W.
module icon_store #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int DISP   = 20,
    parameter int DOTS   = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [ADDR_W-1:0]    raddr,
    output logic [DATA_W-1:0]    rdata,
    output logic [DISP*DOTS-1:0] dots_flat
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage: cleared by reset, one byte written per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read port: full byte at the requested address.
    always_comb rdata = mem[raddr];

    // Parallel tap of the dot bits of every display entry.
    for (genvar n = 0; n < DISP; n++) begin : g_tap
        assign dots_flat[n*DOTS +: DOTS] = mem[n][DOTS-1:0];
    end

endmodule

// File: rtl/icon_seg_map.sv
// Module: maps the dot bits of each entry onto the segment vector.
// The highest dot bit of an entry drives the lowest segment of its group.
// Assumes: dots_flat packs entry n in bits [n*DOTS +: DOTS].
module icon_seg_map #(
    parameter int DISP = 20,
    parameter int DOTS = 5
) (
    input  logic [DISP*DOTS-1:0] dots_flat,
    output logic [DISP*DOTS-1:0] seg
);

    for (genvar n = 0; n < DISP; n++) begin : g_ent
        for (genvar b = 0; b < DOTS; b++) begin : g_bit
            assign seg[n*DOTS + (DOTS-1-b)] = dots_flat[n*DOTS + b];
        end
    end

endmodule

// File: rtl/icon_seg_ram.sv
// Top: icon segment RAM. It ties the stepping pointer, the byte storage
// and the segment mapper together.
// Assumes: the host issues at most one write per cycle.
module icon_seg_ram
    import icon_ram_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int DISP   = 20,
    parameter int DOTS   = 5,
    localparam int SEG_W = DISP * DOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic [ADDR_W-1:0] ptr_value,
    input  logic              dir_load,
    input  logic              dir_down,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEG_W-1:0]  seg_o
);

    logic [ADDR_W-1:0] cur_ptr;
    step_dir_e         cur_mode;
    logic [SEG_W-1:0]  dots_flat;

    icon_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_value),
        .dir_set  (dir_load),
        .dir_val  (dir_down),
        .step     (wr_en),
        .ptr      (cur_ptr),
        .mode     (cur_mode)
    );

    icon_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DISP   (DISP),
        .DOTS   (DOTS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .waddr     (cur_ptr),
        .wdata     (wr_data),
        .raddr     (cur_ptr),
        .rdata     (rd_data),
        .dots_flat (dots_flat)
    );

    icon_seg_map #(.DISP(DISP), .DOTS(DOTS)) u_map (
        .dots_flat (dots_flat),
        .seg       (seg_o)
    );

endmodule

// File: rtl/icon_seg_ram_chk.sv
// Checker: temporal properties of the icon segment RAM, bound to the top.
// Assumes: at most one write per cycle, and defined inputs under strobes.
module icon_seg_ram_chk #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 8,
    parameter int DISP   = 20,
    parameter int DOTS   = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ptr_load,
    input logic [ADDR_W-1:0]    ptr_value,
    input logic                 dir_load,
    input logic                 dir_down,
    input logic                 wr_en,
    input logic [DATA_W-1:0]    wr_data,
    input logic [ADDR_W-1:0]    cur_ptr,
    input logic                 cur_mode,
    input logic [DISP*DOTS-1:0] seg_o
);

    localparam logic [ADDR_W-1:0] LIM = ADDR_W'(DISP);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic              prev_wr;
    logic [ADDR_W-1:0] prev_addr;
    logic [DOTS-1:0]   prev_dots;
    logic [DOTS-1:0]   prev_rev;

    // Capture the last write so its segment effect can be checked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_wr   <= 1'b0;
            prev_addr <= '0;
            prev_dots <= '0;
        end else begin
            prev_wr   <= wr_en;
            prev_addr <= cur_ptr;
            prev_dots <= wr_data[DOTS-1:0];
        end
    end

    // Expected dot order inside a group (bit 0 lands last).
    always_comb begin
        for (int b = 0; b < DOTS; b++) prev_rev[DOTS-1-b] = prev_dots[b];
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cur_ptr == '0 && cur_mode == 1'b0 && seg_o == '0)); // R1
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> cur_ptr == $past(ptr_value)); // R3
    AST_DIR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        dir_load |=> cur_mode == $past(dir_down)); // R4
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_load && cur_mode == 1'b0) |=> cur_ptr == $past(cur_ptr) + ONE); // R5
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ptr_load && cur_mode == 1'b1) |=> cur_ptr == $past(cur_ptr) - ONE); // R6
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ptr_load) |=> $stable(cur_ptr)); // R7
    AST_SEG_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_wr && prev_addr < LIM) |-> seg_o[int'(prev_addr)*DOTS +: DOTS] == prev_rev); // R8
    AST_SCRATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cur_ptr >= LIM) |=> $stable(seg_o)); // R9

endmodule

bind icon_seg_ram icon_seg_ram_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DISP   (DISP),
    .DOTS   (DOTS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_load  (ptr_load),
    .ptr_value (ptr_value),
    .dir_load  (dir_load),
    .dir_down  (dir_down),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .cur_ptr   (cur_ptr),
    .cur_mode  (cur_mode),
    .seg_o     (seg_o)
);

// File: tb/tb_icon_seg_ram.sv
`timescale 1ns/1ps
module tb_icon_seg_ram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_load = 1'b0;
    logic [4:0]  ptr_value = '0;
    logic        dir_load = 1'b0;
    logic        dir_down = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [99:0] seg_o;

    logic [7:0]  exp_mem [32];
    logic [4:0]  exp_ptr;
    logic        exp_dn;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    icon_seg_ram dut (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_value(ptr_value),
        .dir_load(dir_load), .dir_down(dir_down), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .seg_o(seg_o)
    );

    always #2 clk = ~clk;

    function automatic logic [99:0] exp_seg();
        logic [99:0] s;
        for (int n = 0; n < 20; n++)
            for (int b = 0; b < 5; b++) s[n*5 + 4 - b] = exp_mem[n][b];
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag);
        check(rd_data == exp_mem[exp_ptr], tag, 128'(rd_data), 128'(exp_mem[exp_ptr]));
    endtask

    task automatic chk_seg(input string tag);
        check(seg_o == exp_seg(), tag, 128'(seg_o), 128'(exp_seg()));
    endtask

    task automatic step_model_wr(input logic [7:0] d);
        exp_mem[exp_ptr] = d;
        exp_ptr = exp_dn ? exp_ptr - 5'd1 : exp_ptr + 5'd1;
    endtask

    task automatic do_load(input logic [4:0] a);
        ptr_load = 1'b1; ptr_value = a;
        @(negedge clk);
        ptr_load = 1'b0;
        exp_ptr = a;
    endtask

    task automatic do_dir(input logic d);
        dir_load = 1'b1; dir_down = d;
        @(negedge clk);
        dir_load = 1'b0;
        exp_dn = d;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        step_model_wr(d);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 32; i++) exp_mem[i] = '0;
        exp_ptr = '0;
        exp_dn = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        logic [99:0] seg_keep;
        @(negedge clk);
        do_reset();
        // R1: cleared state and upward default
        check(seg_o == '0, "R1 seg after reset", 128'(seg_o), 128'(0));
        check(rd_data == '0, "R1 rd after reset", 128'(rd_data), 128'(0));
        do_write(8'hA5);
        do_write(8'h3C);
        do_load(5'd0); chk_rd("R1 start at 0");
        do_load(5'd1); chk_rd("R1 default increments");

        // R5/R8/R10: upward sweep over the full range, segments after each write
        do_load(5'd0);
        for (int a = 0; a < 32; a++) begin
            do_write(8'(a * 37 + 5));
            chk_seg("R8 R10 seg after up write");
            chk_rd("R5 pointer stepped up");
        end
        // R6: upward wrap 31 -> 0
        check(exp_ptr == 5'd0, "R6 model wrap", 128'(exp_ptr), 128'(0));
        chk_rd("R6 wrap up to 0");

        // R2: readback of every address
        for (int a = 0; a < 32; a++) begin
            do_load(5'(a));
            chk_rd("R2 full byte readback");
        end
        // R7: idle cycles keep the pointer
        do_load(5'd9);
        repeat (4) @(negedge clk);
        chk_rd("R7 idle hold");

        // R4/R5/R6: downward sweep from 31, wrapping to 31
        do_dir(1'b1);
        do_load(5'd31);
        for (int a = 31; a >= 0; a--) begin
            do_write(8'(a * 91 + 200));
            chk_seg("R8 seg after down write");
            chk_rd("R5 pointer stepped down");
        end
        check(exp_ptr == 5'd31, "R6 model wrap down", 128'(exp_ptr), 128'(31));
        chk_rd("R6 wrap down to 31");

        // R9: scratch entries and upper bits leave seg unchanged
        do_dir(1'b0);
        do_load(5'd0);
        seg_keep = seg_o;
        for (int a = 0; a < 32; a++) begin
            if (a < 20) do_write({3'(a + 3), exp_mem[a][4:0]});
            else        do_write(8'(a * 53 + 1));
            check(seg_o == seg_keep, "R9 seg unchanged", 128'(seg_o), 128'(seg_keep));
        end
        for (int a = 0; a < 32; a++) begin
            do_load(5'(a));
            chk_rd("R2 upper bits readback");
        end

        // R3: load and write in the same cycle
        do_load(5'd10);
        ptr_load = 1'b1; ptr_value = 5'd3; wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        ptr_load = 1'b0; wr_en = 1'b0;
        exp_mem[10] = 8'h77; exp_ptr = 5'd3;
        chk_rd("R3 load wins over step");
        chk_seg("R3 seg for old address");
        do_load(5'd10); chk_rd("R3 write used old pointer");

        // R4: direction change with a write in the same cycle
        do_load(5'd7);
        dir_load = 1'b1; dir_down = 1'b1; wr_en = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        dir_load = 1'b0; wr_en = 1'b0;
        step_model_wr(8'h5A); exp_dn = 1'b1;
        check(exp_ptr == 5'd8, "R4 model old dir", 128'(exp_ptr), 128'(8));
        chk_rd("R4 old direction used");
        do_write(8'hC3);
        chk_rd("R4 new direction next cycle");
        chk_seg("R8 seg after dir test");

        // R1: reset mid-run clears everything
        do_reset();
        check(seg_o == '0, "R1 seg after second reset", 128'(seg_o), 128'(0));
        chk_rd("R1 rd after second reset");
        do_write(8'h11);
        chk_rd("R1 upward after second reset");
        do_load(5'd0); chk_rd("R1 first write at 0");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule